// File: doc/BRIEF.md
# Eight-Operation Combinational ALU

This block is a purely combinational arithmetic-logic unit of parameterised width, 32 bits by default. Two operand words and a three-bit operation code enter. One result word of the same width comes out in the same cycle. No clock, register or flag is involved.

The operations are:
- wrapping addition and subtraction;
- bitwise inversion of the first operand;
- bitwise and, or and exclusive-or;
- an unsigned less-than test and an equality test.

Each test returns 0 or 1, zero-extended to the full width. A datapath selects the operation by driving the code and reads the result combinationally.

Top module: `octal_alu`

## Requirements
- R1: Code 3'd0 gives opnd_a + opnd_b modulo 2^WIDTH, with the carry out discarded.
- R2: Code 3'd1 gives opnd_a - opnd_b modulo 2^WIDTH, so a negative difference appears as its two's-complement value.
- R3: Code 3'd2 gives the bitwise inverse of opnd_a, and opnd_b has no effect on the result.
- R4: Code 3'd3 gives the bitwise and of the operands.
- R5: Code 3'd4 gives the bitwise or of the operands.
- R6: Code 3'd5 gives the bitwise exclusive-or of the operands.
- R7: Code 3'd6 gives 1 when opnd_a < opnd_b as unsigned numbers, else 0.
- R8: Code 3'd7 gives 1 when opnd_a equals opnd_b, else 0.
- R9: For codes 3'd6 and 3'd7, bits WIDTH-1 down to 1 of the result are zero.
- R10: The result follows any input change with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Result word |

## Verification
The bound checker tests each input combination as it settles, using inverse relations rather than the forward formula:
- a sum minus b must equal a;
- a difference plus b must equal a;
- an inverse must be disjoint from a and cover every bit;
- an and result must lie inside both operands;
- a compare result must have its upper bits at zero;
- an equality result of 1 implies equal operands.

Only the bench scenarios can show the following:
- that a compare returns 1 in exactly the right cases;
- that b really has no effect on inversion;
- that or and exclusive-or produce the right values;
- that the result updates without any clock edge.

// File: rtl/octal_alu_pkg.sv
package octal_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_INV = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5,
        OP_LTU = 3'd6,
        OP_EQ  = 3'd7
    } alu_op_e;

endpackage

// File: rtl/octal_alu_addsub.sv
module octal_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o
);
    localparam int PadW = WIDTH - 1;

    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH-1:0] cin_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        cin_d   = {{PadW{1'b0}}, sub_i};
        sum_o   = a_i + b_eff_d + cin_d;
    end
endmodule

// File: rtl/octal_alu_bitwise.sv
module octal_alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] inv_o,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o
);
    always_comb begin
        inv_o = ~a_i;
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
    end
endmodule

// File: rtl/octal_alu_compare.sv
module octal_alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             ltu_o,
    output logic             eq_o
);
    always_comb begin
        ltu_o = (a_i < b_i);
        eq_o  = ~|(a_i ^ b_i);
    end
endmodule

// File: rtl/octal_alu.sv
module octal_alu
    import octal_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result
);
    localparam int PadW = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } alu_out_t;

    alu_out_t         out_d;
    logic [WIDTH-1:0] addsub_d;
    logic [WIDTH-1:0] inv_d;
    logic [WIDTH-1:0] and_d;
    logic [WIDTH-1:0] or_d;
    logic [WIDTH-1:0] xor_d;
    logic             ltu_d;
    logic             eq_d;
    logic             sub_d;

    assign sub_d = (op_sel == OP_SUB);

    octal_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .sub_i (sub_d),
        .sum_o (addsub_d)
    );

    octal_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .inv_o (inv_d),
        .and_o (and_d),
        .or_o  (or_d),
        .xor_o (xor_d)
    );

    octal_alu_compare #(.WIDTH(WIDTH)) u_compare (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .ltu_o (ltu_d),
        .eq_o  (eq_d)
    );

    always_comb begin
        out_d = '0;
        case (alu_op_e'(op_sel))
            OP_ADD:  out_d.word = addsub_d;
            OP_SUB:  out_d.word = addsub_d;
            OP_INV:  out_d.word = inv_d;
            OP_AND:  out_d.word = and_d;
            OP_OR:   out_d.word = or_d;
            OP_XOR:  out_d.word = xor_d;
            OP_LTU:  out_d.word = {{PadW{1'b0}}, ltu_d};
            OP_EQ:   out_d.word = {{PadW{1'b0}}, eq_d};
            default: out_d.word = '0;
        endcase
    end

    assign result = out_d.word;
endmodule

// File: rtl/octal_alu_chk.sv
module octal_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result
);
    always_comb begin
        if (op_sel == 3'd0) begin
            AST_ADD_INVERSE: assert ((result - opnd_b) == opnd_a); // R1
        end
        if (op_sel == 3'd1) begin
            AST_SUB_INVERSE: assert ((result + opnd_b) == opnd_a); // R2
        end
        if (op_sel == 3'd2) begin
            AST_INV_COMPLEMENT: assert (((result & opnd_a) == '0) && ((result | opnd_a) == '1)); // R3
        end
        if (op_sel == 3'd3) begin
            AST_AND_SUBSET: assert (((result & ~opnd_a) == '0) && ((result & ~opnd_b) == '0)); // R4
        end
        if (op_sel == 3'd6 || op_sel == 3'd7) begin
            AST_CMP_NARROW: assert (result[WIDTH-1:1] == '0); // R9
        end
        if (op_sel == 3'd7 && result[0]) begin
            AST_EQ_IMPLIES_SAME: assert ((opnd_a ^ opnd_b) == '0); // R8
        end
    end
endmodule

bind octal_alu octal_alu_chk #(.WIDTH(WIDTH)) u_octal_alu_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .result (result)
);

// File: tb/test_octal_alu.sv
module test_octal_alu;
    localparam int WIDTH = 32;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned MOD = 64'd1 << WIDTH;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] a = '0;
    logic [WIDTH-1:0] b = '0;
    logic [2:0]       op = 3'd0;
    logic [WIDTH-1:0] res;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    octal_alu #(.WIDTH(WIDTH)) i_octal_alu (
        .opnd_a (a),
        .opnd_b (b),
        .op_sel (op),
        .result (res)
    );

    function automatic logic [WIDTH-1:0] model(input logic [2:0] o,
                                               input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y);
        longint unsigned lx = longint'(x);
        longint unsigned ly = longint'(y);
        longint unsigned r = 0;
        case (o)
            3'd0: r = (lx + ly) % MOD;
            3'd1: r = (lx + MOD - ly) % MOD;
            3'd2: r = (MOD - 1) - lx;
            3'd3: for (int i = 0; i < WIDTH; i++) r |= longint'(x[i] && y[i]) << i;
            3'd4: for (int i = 0; i < WIDTH; i++) r |= longint'(x[i] || y[i]) << i;
            3'd5: for (int i = 0; i < WIDTH; i++) r |= longint'(x[i] != y[i]) << i;
            3'd6: r = (lx < ly) ? 1 : 0;
            default: r = (lx == ly) ? 1 : 0;
        endcase
        return r[WIDTH-1:0];
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7 R9";
            default: return "R8 R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] exp);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, res, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [WIDTH-1:0] x,
                         input logic [WIDTH-1:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
        check(tag_of(o), model(o, x, y));
    endtask

    initial begin
        int unsigned seed = 32'd12345;
        logic [WIDTH-1:0] pa[6];
        logic [WIDTH-1:0] pb[6];
        void'($urandom(seed));
        pa[0] = 32'd5;          pb[0] = 32'd3;
        pa[1] = 32'd101010;     pb[1] = 32'd101010;
        pa[2] = 32'hFFFF_FFFC;  pb[2] = 32'hFFFF_FFFF;
        pa[3] = 32'd4264115;    pb[3] = 32'd2;
        pa[4] = 32'd2;          pb[4] = 32'd9;
        pa[5] = 32'hFFFF_FFFF;  pb[5] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // idle inputs all zero: add of zeros reads zero
        check("R1", '0);
        for (int o = 0; o < 8; o++)
            for (int k = 0; k < 6; k++) apply(3'(o), pa[k], pb[k]);
        // R1 carry out dropped, R2 negative wrap
        apply(3'd0, 32'hFFFF_FFFF, 32'd1);
        apply(3'd1, 32'd0, 32'd1);
        // R7 boundary: equal is not less, one less is less
        apply(3'd6, 32'h8000_0000, 32'h8000_0000);
        apply(3'd6, 32'h7FFF_FFFF, 32'h8000_0000);
        // R3: b has no effect on the inverse
        @(negedge clk); op = 3'd2; a = 32'h1234_5678; b = 32'h0;
        #1; check("R3", 32'hEDCB_A987);
        b = 32'hFFFF_FFFF;
        #1; check("R3", 32'hEDCB_A987);
        // R10: the result changes with no clock edge between
        @(negedge clk); op = 3'd5; a = 32'hF0F0_F0F0; b = 32'h0F0F_0F0F;
        #1; check("R10", 32'hFFFF_FFFF);
        op = 3'd7;
        #1; check("R10", 32'd0);
        b = 32'hF0F0_F0F0;
        #1; check("R10", 32'd1);
        // random stimulus on every operation
        for (int n = 0; n < 400; n++) begin
            logic [WIDTH-1:0] ra = $urandom;
            logic [WIDTH-1:0] rb = (n % 5 == 0) ? ra : $urandom;
            apply(3'($urandom % 8), ra, rb);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule